// File: doc/BRIEF.md
# Monitor-and-Wait Wake Controller

This block holds the wake logic of a core's monitor/wait idle pair. A monitor request checks its extension operand and, if that operand is zero, arms a watch on the cache line that holds the given address. A following wait request checks its own extension operand, decodes the hint into a target power state and substate, and parks the core in that state. A wake pulse ends the wait, and a wake-reason code says why the core woke.

Three events can end a wait. A store can hit the watched line. A 32-bit cycle-count timeout can expire, which is available only on the timed variant. A pending interrupt can arrive, but only when the wait's interrupt-break bit is set. If the monitor is not armed, or the line was already written after arming, a wait ends at once without sleeping. Every wake disarms the monitor. Illegal operand encodings raise a one-cycle fault pulse and change no state.

Top module: `mwait_wake_ctrl`

## Requirements
- R1: A monitor request with an all-zero extension operand sets `armed` on the following clock edge and records the address to watch. After reset, `armed`, `waiting`, `wake` and `fault` are low.
- R2: A monitor request with any extension bit set raises `fault` for one cycle and leaves `armed` and the watched line unchanged.
- R3: A wait request faults and does not start a wait in either of these cases: any of extension bits 31:2 is set (both variants), or extension bit 1 is set on the untimed variant (`wait_timed`=0).
- R4: An accepted wait drives `tgt_state` = hint[7:4] and `tgt_substate` = hint[3:0], and holds `waiting` high until the wake.
- R5: During a wait, a store to any byte of the watched 64-byte line gives a wake with reason 2'b00 on the next edge. A store to a different line has no effect.
- R6: During a wait whose extension bit 0 is set, a high `irq_pending` gives a wake with reason 2'b10 on the next edge. When bit 0 is clear, `irq_pending` is ignored.
- R7: A timed wait with extension bit 1 set and count N gives a wake with reason 2'b01 on the (N+1)-th edge after the edge that accepted the wait, unless another event wakes it first. With bit 1 clear, no timeout occurs.
- R8: A legal wait issued while the monitor is unarmed, or after a store has hit the armed line, gives a wake with reason 2'b11 on the next edge, and `waiting` stays low.
- R9: Every wake clears `armed`, so the next wait ends immediately unless a new monitor request comes first.
- R10: When several wake events occur in the same cycle, the reason follows the priority interrupt (2'b10) over store hit (2'b00) over timeout (2'b01).
- R11: `wake` and `wake_reason` are valid for a single cycle, and `waiting` is low in the cycle in which `wake` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_req | input | 1 | Monitor request strobe |
| mon_addr | input | 48 | Address to watch |
| mon_ext | input | 32 | Monitor extension operand; must be zero |
| wait_req | input | 1 | Wait request strobe; ignored while waiting |
| wait_timed | input | 1 | Selects the timed wait variant |
| wait_hint | input | 8 | Hint: [7:4] target state, [3:0] substate |
| wait_ext | input | 32 | Wait extension: bit0 interrupt-break, bit1 timer enable |
| wait_count | input | 32 | Timeout in reference cycles (timed variant) |
| st_valid | input | 1 | A store is observed this cycle |
| st_addr | input | 48 | Byte address of the observed store |
| irq_pending | input | 1 | An interrupt is pending |
| armed | output | 1 | Monitor armed |
| waiting | output | 1 | Core is in the low-power wait |
| tgt_state | output | 4 | Decoded target state |
| tgt_substate | output | 4 | Decoded substate |
| wake | output | 1 | One-cycle wake pulse |
| wake_reason | output | 2 | 00 store, 01 timeout, 10 interrupt, 11 immediate |
| fault | output | 1 | One-cycle general-protection fault pulse |

## Verification
The store watch is tried with a store to the last byte of the watched line and with a store to the first byte of the neighbouring line. This separates a correct line-granular compare from a full-address compare and from a compare with too many bits masked. Interrupts are applied with the break bit clear and then set, and timeouts are tried with the enable bit set and clear, so a wake path that ignores its enable is caught. Simultaneous interrupt, store and timeout events, with count zero, show that the priority order is right. Waits issued when the monitor is unarmed, when the line was already hit, and right after a wake show that the immediate-exit and disarm rules are right.

// File: rtl/mwait_wake_pkg.sv
package mwait_wake_pkg;

   typedef enum logic [1:0] {
      WHY_STORE   = 2'b00,
      WHY_TIMEOUT = 2'b01,
      WHY_IRQ     = 2'b10,
      WHY_IMMED   = 2'b11
   } wake_why_e;

   typedef struct packed {
      logic [3:0] state;
      logic [3:0] sub;
   } hint_dec_t;

endpackage

// File: rtl/mwait_opchk.sv
module mwait_opchk #(
   parameter int EXT_W = 32
) (
   input  logic [EXT_W-1:0]          mon_ext,
   input  logic [EXT_W-1:0]          wait_ext,
   input  logic                      wait_timed,
   input  logic [7:0]                hint,
   output logic                      mon_bad,
   output logic                      wait_bad,
   output mwait_wake_pkg::hint_dec_t hint_dec
);
   generate
      if (EXT_W < 3) begin : g_bad_ext
         $error("mwait_opchk: EXT_W must be at least 3");
      end
   endgenerate

   always_comb begin
      mon_bad        = |mon_ext;
      wait_bad       = (|wait_ext[EXT_W-1:2]) | (~wait_timed & wait_ext[1]);
      hint_dec.state = hint[7:4];
      hint_dec.sub   = hint[3:0];
   end
endmodule

// File: rtl/mwait_line_watch.sv
module mwait_line_watch #(
   parameter int ADDR_W     = 48,
   parameter int LINE_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm,
   input  logic [ADDR_W-1:0] arm_addr,
   input  logic              clear,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   output logic              armed,
   output logic              hit_seen,
   output logic              st_hit
);
   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << LINE_LSB;

   generate
      if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("mwait_line_watch: LINE_BYTES must be a power of two");
      end
      if (ADDR_W <= LINE_LSB) begin : g_bad_addr
         $error("mwait_line_watch: ADDR_W too small for LINE_BYTES");
      end
   endgenerate

   logic [ADDR_W-1:0] watch_q;

   assign st_hit = armed & st_valid & (((st_addr ^ watch_q) & TAG_MASK) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         hit_seen <= 1'b0;
         watch_q  <= '0;
      end else if (arm) begin
         armed    <= 1'b1;
         hit_seen <= 1'b0;
         watch_q  <= arm_addr;
      end else if (clear) begin
         armed    <= 1'b0;
         hit_seen <= 1'b0;
      end else if (st_hit) begin
         hit_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/mwait_timeout.sv
module mwait_timeout #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             load_run,
   input  logic [CNT_W-1:0] load_val,
   input  logic             stop,
   output logic             expired
);
   logic             run_q;
   logic [CNT_W-1:0] rem_q;

   assign expired = run_q & (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         rem_q <= '0;
      end else if (load) begin
         run_q <= load_run;
         rem_q <= load_val;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (run_q && rem_q != '0) begin
         rem_q <= rem_q - 1'b1;
      end
   end
endmodule

// File: rtl/mwait_wake_ctrl.sv
module mwait_wake_ctrl #(
   parameter int ADDR_W     = 48,
   parameter int EXT_W      = 32,
   parameter int CNT_W      = 32,
   parameter int LINE_BYTES = 64,
   parameter bit TIMER_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mon_req,
   input  logic [ADDR_W-1:0] mon_addr,
   input  logic [EXT_W-1:0]  mon_ext,
   input  logic              wait_req,
   input  logic              wait_timed,
   input  logic [7:0]        wait_hint,
   input  logic [EXT_W-1:0]  wait_ext,
   input  logic [CNT_W-1:0]  wait_count,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              irq_pending,
   output logic              armed,
   output logic              waiting,
   output logic [3:0]        tgt_state,
   output logic [3:0]        tgt_substate,
   output logic              wake,
   output logic [1:0]        wake_reason,
   output logic              fault
);
   import mwait_wake_pkg::*;

   logic      mon_bad, wait_bad, hit_seen, st_hit, tmr_expired;
   hint_dec_t hint_dec, hint_q;
   logic      waiting_q, irq_brk_q, wake_q, fault_q;
   wake_why_e why_q, why_d;

   mwait_opchk #(.EXT_W(EXT_W)) u_opchk (
      .mon_ext   (mon_ext),
      .wait_ext  (wait_ext),
      .wait_timed(wait_timed),
      .hint      (wait_hint),
      .mon_bad   (mon_bad),
      .wait_bad  (wait_bad),
      .hint_dec  (hint_dec)
   );

   logic mon_live, wait_live, accept_wait, enter_sleep, immed;
   logic irq_wake, st_wake, to_wake, any_wake, arm;

   assign mon_live    = mon_req & ~waiting_q;
   assign wait_live   = wait_req & ~waiting_q;
   assign accept_wait = wait_live & ~wait_bad;
   assign enter_sleep = accept_wait & armed & ~hit_seen & ~st_hit;
   assign immed       = accept_wait & ~enter_sleep;
   assign irq_wake    = waiting_q & irq_brk_q & irq_pending;
   assign st_wake     = waiting_q & st_hit;
   assign to_wake     = waiting_q & tmr_expired;
   assign any_wake    = irq_wake | st_wake | to_wake | immed;
   assign arm         = mon_live & ~mon_bad;

   mwait_line_watch #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_watch (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm     (arm),
      .arm_addr(mon_addr),
      .clear   (any_wake),
      .st_valid(st_valid),
      .st_addr (st_addr),
      .armed   (armed),
      .hit_seen(hit_seen),
      .st_hit  (st_hit)
   );

   generate
      if (TIMER_EN) begin : g_timer
         mwait_timeout #(.CNT_W(CNT_W)) u_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (enter_sleep),
            .load_run(wait_timed & wait_ext[1]),
            .load_val(wait_count),
            .stop    (any_wake),
            .expired (tmr_expired)
         );
      end else begin : g_no_timer
         assign tmr_expired = 1'b0;
      end
   endgenerate

   always_comb begin
      if (immed)         why_d = WHY_IMMED;
      else if (irq_wake) why_d = WHY_IRQ;
      else if (st_wake)  why_d = WHY_STORE;
      else               why_d = WHY_TIMEOUT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waiting_q <= 1'b0;
         irq_brk_q <= 1'b0;
         wake_q    <= 1'b0;
         fault_q   <= 1'b0;
         why_q     <= WHY_STORE;
         hint_q    <= '0;
      end else begin
         wake_q  <= any_wake;
         fault_q <= (mon_live & mon_bad) | (wait_live & wait_bad);
         if (any_wake) why_q <= why_d;
         if (enter_sleep) begin
            waiting_q <= 1'b1;
            irq_brk_q <= wait_ext[0];
            hint_q    <= hint_dec;
         end else if (any_wake) begin
            waiting_q <= 1'b0;
         end
      end
   end

   assign waiting      = waiting_q;
   assign wake         = wake_q;
   assign wake_reason  = why_q;
   assign fault        = fault_q;
   assign tgt_state    = hint_q.state;
   assign tgt_substate = hint_q.sub;
endmodule

// File: rtl/mwait_wake_ctrl_chk.sv
module mwait_wake_ctrl_chk #(
   parameter int EXT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mon_req,
   input logic [EXT_W-1:0] mon_ext,
   input logic             wait_req,
   input logic [EXT_W-1:0] wait_ext,
   input logic             waiting,
   input logic             armed,
   input logic             wake,
   input logic             fault
);
   // R2
   mon_fault_keeps_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_req && !waiting && !wait_req && (mon_ext != '0)) |=> (fault && armed == $past(armed)));

   // R3
   wait_reserved_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_req && !waiting && (|wait_ext[EXT_W-1:2])) |=> (fault && !waiting));

   // R9
   wake_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake && !$past(mon_req)) |-> !armed);

   // R11
   wake_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> !waiting);

   // R8
   wait_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      waiting |-> armed);
endmodule

bind mwait_wake_ctrl mwait_wake_ctrl_chk #(.EXT_W(EXT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mon_req (mon_req),
   .mon_ext (mon_ext),
   .wait_req(wait_req),
   .wait_ext(wait_ext),
   .waiting (waiting),
   .armed   (armed),
   .wake    (wake),
   .fault   (fault)
);

// File: tb/mwait_wake_ctrl_test.sv
module mwait_wake_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mon_req = 1'b0;
   logic [47:0] mon_addr = '0;
   logic [31:0] mon_ext = '0;
   logic        wait_req = 1'b0;
   logic        wait_timed = 1'b0;
   logic [7:0]  wait_hint = '0;
   logic [31:0] wait_ext = '0;
   logic [31:0] wait_count = '0;
   logic        st_valid = 1'b0;
   logic [47:0] st_addr = '0;
   logic        irq_pending = 1'b0;
   logic        armed, waiting, wake, fault;
   logic [3:0]  tgt_state, tgt_substate;
   logic [1:0]  wake_reason;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   mwait_wake_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .mon_req(mon_req), .mon_addr(mon_addr), .mon_ext(mon_ext),
      .wait_req(wait_req), .wait_timed(wait_timed), .wait_hint(wait_hint),
      .wait_ext(wait_ext), .wait_count(wait_count),
      .st_valid(st_valid), .st_addr(st_addr), .irq_pending(irq_pending),
      .armed(armed), .waiting(waiting), .tgt_state(tgt_state),
      .tgt_substate(tgt_substate), .wake(wake), .wake_reason(wake_reason),
      .fault(fault)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_mon(input logic [47:0] a, input logic [31:0] e);
      @(negedge clk);
      mon_req = 1'b1; mon_addr = a; mon_ext = e;
      @(negedge clk);
      mon_req = 1'b0; mon_ext = '0;
   endtask

   task automatic do_wait(input logic t, input logic [31:0] e,
                          input logic [7:0] h, input logic [31:0] n);
      @(negedge clk);
      wait_req = 1'b1; wait_timed = t; wait_ext = e; wait_hint = h; wait_count = n;
      @(negedge clk);
      wait_req = 1'b0;
   endtask

   task automatic do_store(input logic [47:0] a);
      @(negedge clk);
      st_valid = 1'b1; st_addr = a;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   task automatic t_reset;
      chk("R1", "armed after reset", armed, 0);
      chk("R1", "waiting after reset", waiting, 0);
      chk("R1", "wake after reset", wake, 0);
      chk("R1", "fault after reset", fault, 0);
   endtask

   task automatic t_monitor;
      do_mon(48'h2000, 32'h1);
      chk("R2", "fault on bad monitor", fault, 1);
      chk("R2", "not armed by bad monitor", armed, 0);
      @(negedge clk);
      chk("R2", "fault is one pulse", fault, 0);
      do_mon(48'h2000, 32'h0);
      chk("R1", "armed by good monitor", armed, 1);
      chk("R1", "no fault on good monitor", fault, 0);
      do_mon(48'h5000, 32'h4);
      chk("R2", "fault on bad rearm", fault, 1);
      chk("R2", "arm kept on bad rearm", armed, 1);
      do_wait(1'b0, 32'h0, 8'h00, 0);
      chk("R1", "wait entered", waiting, 1);
      do_store(48'h5000);
      chk("R2", "bad rearm did not move line", wake, 0);
      do_store(48'h2010);
      chk("R1", "wake on recorded line", wake, 1);
      chk("R5", "reason store", wake_reason, 2'b00);
   endtask

   task automatic t_wait_faults;
      do_mon(48'h3000, 32'h0);
      do_wait(1'b0, 32'h2, 8'h11, 0);
      chk("R3", "untimed bit1 faults", fault, 1);
      chk("R3", "untimed bit1 no wait", waiting, 0);
      do_wait(1'b1, 32'h4, 8'h11, 0);
      chk("R3", "bit2 faults", fault, 1);
      chk("R3", "bit2 no wait", waiting, 0);
      do_wait(1'b1, 32'h8000_0000, 8'h11, 0);
      chk("R3", "bit31 faults", fault, 1);
      chk("R3", "no wake from faulting wait", wake, 0);
      chk("R3", "arm kept after faults", armed, 1);
   endtask

   task automatic t_hint_store;
      do_wait(1'b0, 32'h0, 8'h5A, 0);
      chk("R4", "waiting", waiting, 1);
      chk("R4", "target state", tgt_state, 4'h5);
      chk("R4", "substate", tgt_substate, 4'hA);
      do_store(48'h3040);
      chk("R5", "next line ignored", wake, 0);
      chk("R5", "still waiting", waiting, 1);
      do_store(48'h303F);
      chk("R5", "last byte of line wakes", wake, 1);
      chk("R5", "reason store", wake_reason, 2'b00);
      chk("R11", "waiting low with wake", waiting, 0);
      chk("R9", "disarmed by wake", armed, 0);
      @(negedge clk);
      chk("R11", "wake one cycle", wake, 0);
   endtask

   task automatic t_irq;
      do_mon(48'h4000, 32'h0);
      do_wait(1'b0, 32'h0, 8'h20, 0);
      irq_pending = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R6", "masked irq ignored", wake, 0);
      end
      irq_pending = 1'b0;
      chk("R6", "still waiting", waiting, 1);
      do_store(48'h4000);
      chk("R6", "store ends masked wait", wake_reason, 2'b00);
      do_mon(48'h4000, 32'h0);
      do_wait(1'b0, 32'h1, 8'h20, 0);
      irq_pending = 1'b1;
      @(negedge clk);
      irq_pending = 1'b0;
      chk("R6", "irq wakes", wake, 1);
      chk("R6", "reason irq", wake_reason, 2'b10);
   endtask

   task automatic t_timeout;
      do_mon(48'h6000, 32'h0);
      do_wait(1'b1, 32'h2, 8'h00, 32'd5);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk("R7", "no early timeout", wake, 0);
      end
      @(negedge clk);
      chk("R7", "timeout wake", wake, 1);
      chk("R7", "reason timeout", wake_reason, 2'b01);
      do_mon(48'h6000, 32'h0);
      do_wait(1'b1, 32'h0, 8'h00, 32'd2);
      for (int i = 0; i < 8; i++) @(negedge clk);
      chk("R7", "no timeout when disabled", waiting, 1);
      do_store(48'h6001);
      chk("R7", "store ends untimed wait", wake, 1);
   endtask

   task automatic t_immediate;
      do_wait(1'b0, 32'h0, 8'h00, 0);
      chk("R9", "wait after wake is immediate", wake, 1);
      chk("R8", "reason immediate", wake_reason, 2'b11);
      chk("R8", "no sleep", waiting, 0);
      do_mon(48'h7000, 32'h0);
      do_store(48'h7020);
      chk("R8", "store before wait no wake", wake, 0);
      do_wait(1'b0, 32'h0, 8'h00, 0);
      chk("R8", "prior hit exits at once", wake, 1);
      chk("R8", "reason immediate after hit", wake_reason, 2'b11);
      chk("R8", "no sleep after hit", waiting, 0);
   endtask

   task automatic t_priority;
      do_mon(48'h8000, 32'h0);
      do_wait(1'b1, 32'h3, 8'h00, 32'd0);
      irq_pending = 1'b1; st_valid = 1'b1; st_addr = 48'h8008;
      @(negedge clk);
      irq_pending = 1'b0; st_valid = 1'b0;
      chk("R10", "irq beats store and timeout", wake_reason, 2'b10);
      do_mon(48'h8000, 32'h0);
      do_wait(1'b1, 32'h3, 8'h00, 32'd0);
      st_valid = 1'b1; st_addr = 48'h8008;
      @(negedge clk);
      st_valid = 1'b0;
      chk("R10", "store beats timeout", wake_reason, 2'b00);
      do_mon(48'h8000, 32'h0);
      do_wait(1'b1, 32'h2, 8'h00, 32'd0);
      @(negedge clk);
      chk("R10", "timeout alone", wake_reason, 2'b01);
      chk("R10", "timeout alone wakes", wake, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_monitor();
      t_wait_faults();
      t_hint_store();
      t_irq();
      t_timeout();
      t_immediate();
      t_priority();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule